// File: doc/BRIEF.md
# Dual Alarm Comparator with Interrupt Routing

This block holds two independent time-of-day alarms and compares each of them against the live time whenever the time keeper signals a new second. Each alarm has four compare fields: seconds, minutes, hours and weekday. Any field can be made a don't-care, so one alarm can fire once a week, once a day, once an hour, once a minute or on every second. A match sets a sticky pending flag for that alarm. If that alarm's interrupt enable is on, the flag drives an active-low interrupt pin.

A routing bit selects how the alarms reach the pins. With the bit clear, both alarms share the first pin. With it set, alarm 1 moves to the second pin. The block sits behind a simple byte-wide register port. Any read of an alarm's registers acknowledges that alarm. Writing zeros into the status register acknowledges the alarms whose bit positions hold a zero.

The serial front end and the time counter are outside the block. They present the register port and the current time bytes, and they pulse `tick_i` in the cycle in which the time bytes hold the new second.

Top module: `dual_alarm_irq`

## Requirements
- R1: The register map is fixed. Alarm 0 is at 0x07..0x0A and alarm 1 is at 0x0B..0x0E, each holding the seconds, minutes, hours and weekday fields at ascending addresses. Control is at 0x0F: bit 0 enables alarm 0, bit 1 enables alarm 1, and bit 2 is the routing bit. Status is at 0x10: bit 0 is the alarm 0 flag and bit 1 is the alarm 1 flag. A read returns the register's value on `bus_rdata_o` one clock after the read request. Alarm fields read back all 8 bits written. Unused control and status bits read as 0.
- R2: An alarm matches in a cycle with `tick_i` high when every one of its four fields either equals the corresponding time byte exactly or has bit 7 set. A field with bit 7 set matches every value.
- R3: The hour field is compared as the raw encoded byte, including bit 6 (12-hour mode) and bit 5 (PM). A 12-hour alarm byte therefore never matches a 24-hour time byte with the same digits.
- R4: A match sets that alarm's status flag at the next clock edge. The flag stays set through later ticks, matching or not. No flag is set without `tick_i`.
- R5: A write to status clears each flag whose written bit is 0. A written 1 leaves that flag unchanged.
- R6: A read of any address in an alarm's range clears that alarm's flag at the next edge. The other alarm's flag is not affected.
- R7: When a match and a clear (read-acknowledge or status write) fall in the same cycle for one alarm, the match wins and the flag ends up set.
- R8: `irq0_n_o` is low when either of these holds: flag 0 and enable 0 are both set; or the routing bit is 0 and flag 1 and enable 1 are both set. `irq1_n_o` is low when the routing bit is 1 and flag 1 and enable 1 are both set. The pins are registered and follow the flags and control register one clock later.
- R9: Clearing an enable bit releases the pin but leaves the flag set.
- R10: After reset, all alarm fields, the control register and both flags are 0, the routing bit sends both alarms to `irq0_n_o`, and both pins are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse: time bytes hold the new second |
| now_sec_i | input | 8 | Current seconds byte |
| now_min_i | input | 8 | Current minutes byte |
| now_hour_i | input | 8 | Current hour byte (encoded) |
| now_wday_i | input | 8 | Current weekday byte |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid one clock after the read |
| irq0_n_o | output | 1 | Active-low interrupt pin 0 |
| irq1_n_o | output | 1 | Active-low interrupt pin 1 |

## Verification
A second-tick match and a flag clear can land in the same cycle. The clear comes either from reading that alarm's registers or from writing zero to status. The bench provokes both collisions by raising `tick_i` with a matching time in the very cycle that carries the read or the status write. It then reads status and expects the flag still set, because a fresh match must not be lost to the acknowledgement of an earlier one.

// File: rtl/dual_alarm_pkg.sv
package dual_alarm_pkg;
  localparam int FIELD_W    = 8;
  localparam int N_FIELDS   = 4;   // seconds, minutes, hours, weekday
  localparam int N_ALARMS   = 2;
  localparam int IGNORE_BIT = 7;   // field bit that makes the field a don't-care
  localparam int ROUTE_BIT  = 2;   // control bit steering alarm 1

  typedef logic [FIELD_W-1:0] field_t;
  typedef logic [N_FIELDS-1:0][FIELD_W-1:0] tstamp_t;
endpackage

// File: rtl/alarm_slot.sv
module alarm_slot
  import dual_alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BASE   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  field_t            wdata_i,
  input  tstamp_t           now_i,
  output logic              sel_o,
  output logic              hit_o,
  output field_t            rdata_o
);
  localparam int LAST = BASE + N_FIELDS - 1;

  field_t              fld_q [N_FIELDS];
  logic [N_FIELDS-1:0] fld_hit;

  assign sel_o = (addr_i >= ADDR_W'(BASE)) && (addr_i <= ADDR_W'(LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int f = 0; f < N_FIELDS; f++) fld_q[f] <= '0;
    end else if (wr_i) begin
      for (int f = 0; f < N_FIELDS; f++)
        if (addr_i == ADDR_W'(BASE + f)) fld_q[f] <= wdata_i;
    end
  end

  genvar g;
  generate
    for (g = 0; g < N_FIELDS; g++) begin : g_cmp
      assign fld_hit[g] = fld_q[g][IGNORE_BIT] || (fld_q[g] == now_i[g]);
    end
  endgenerate

  assign hit_o = &fld_hit;

  always_comb begin
    rdata_o = '0;
    for (int f = 0; f < N_FIELDS; f++)
      if (addr_i == ADDR_W'(BASE + f)) rdata_o = fld_q[f];
  end

  // R2
  all_ignored_hits_chk: assert property (@(posedge clk) disable iff (rst)
    (fld_q[0][IGNORE_BIT] && fld_q[1][IGNORE_BIT] &&
     fld_q[2][IGNORE_BIT] && fld_q[3][IGNORE_BIT]) |-> hit_o);
endmodule

// File: rtl/alarm_irq_route.sv
module alarm_irq_route
  import dual_alarm_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_i,
  input  logic [N_ALARMS-1:0] hit_i,
  input  logic [N_ALARMS-1:0] clr_i,
  input  logic [N_ALARMS-1:0] en_i,
  input  logic                route_i,
  output logic [N_ALARMS-1:0] flag_o,
  output logic                irq0_n_o,
  output logic                irq1_n_o
);
  logic [N_ALARMS-1:0] flag_q;
  logic [N_ALARMS-1:0] set;

  assign set = {N_ALARMS{tick_i}} & hit_i;

  genvar g;
  generate
    for (g = 0; g < N_ALARMS; g++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)            flag_q[g] <= 1'b0;
        else if (set[g])    flag_q[g] <= 1'b1;   // a new match outranks a clear
        else if (clr_i[g])  flag_q[g] <= 1'b0;
      end

      // R4
      flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q[g] && !clr_i[g]) |=> flag_q[g]);
      // R7
      set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_i && hit_i[g]) |=> flag_q[g]);
      // R6
      clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i[g] && !tick_i) |=> !flag_q[g]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      irq0_n_o <= 1'b1;
      irq1_n_o <= 1'b1;
    end else begin
      irq0_n_o <= !((flag_q[0] && en_i[0]) || (!route_i && flag_q[1] && en_i[1]));
      irq1_n_o <= !(route_i && flag_q[1] && en_i[1]);
    end
  end

  assign flag_o = flag_q;

  // R8
  pin1_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !route_i |=> irq1_n_o);
  // R9
  pins_off_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i == '0) |=> (irq0_n_o && irq1_n_o));
endmodule

// File: rtl/dual_alarm_irq.sv
module dual_alarm_irq
  import dual_alarm_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int ALM0_BASE = 7,
  parameter int ALM1_BASE = 11,
  parameter int CTRL_ADDR = 15,
  parameter int STAT_ADDR = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [7:0]        now_sec_i,
  input  logic [7:0]        now_min_i,
  input  logic [7:0]        now_hour_i,
  input  logic [7:0]        now_wday_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              irq0_n_o,
  output logic              irq1_n_o
);
  localparam int CTRL_W = ROUTE_BIT + 1;

  tstamp_t             now;
  logic [N_ALARMS-1:0] sel, hit, clr, flag;
  field_t              slot_rd [N_ALARMS];
  logic [CTRL_W-1:0]   ctrl_q;
  logic                stat_wr;

  assign now = {now_wday_i, now_hour_i, now_min_i, now_sec_i};

  genvar g;
  generate
    for (g = 0; g < N_ALARMS; g++) begin : g_slot
      alarm_slot #(
        .ADDR_W (ADDR_W),
        .BASE   ((g == 0) ? ALM0_BASE : ALM1_BASE)
      ) u_slot (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .now_i   (now),
        .sel_o   (sel[g]),
        .hit_o   (hit[g]),
        .rdata_o (slot_rd[g])
      );
      assign clr[g] = (bus_rd_i && sel[g]) || (stat_wr && !bus_wdata_i[g]);
    end
  endgenerate

  assign stat_wr = bus_wr_i && (bus_addr_i == ADDR_W'(STAT_ADDR));

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (bus_wr_i && bus_addr_i == ADDR_W'(CTRL_ADDR))
      ctrl_q <= bus_wdata_i[CTRL_W-1:0];
  end

  alarm_irq_route u_route (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick_i),
    .hit_i    (hit),
    .clr_i    (clr),
    .en_i     (ctrl_q[N_ALARMS-1:0]),
    .route_i  (ctrl_q[ROUTE_BIT]),
    .flag_o   (flag),
    .irq0_n_o (irq0_n_o),
    .irq1_n_o (irq1_n_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata_o <= '0;
    end else if (bus_rd_i) begin
      if (sel[0])                                 bus_rdata_o <= slot_rd[0];
      else if (sel[1])                            bus_rdata_o <= slot_rd[1];
      else if (bus_addr_i == ADDR_W'(CTRL_ADDR))  bus_rdata_o <= 8'(ctrl_q);
      else if (bus_addr_i == ADDR_W'(STAT_ADDR))  bus_rdata_o <= 8'(flag);
      else                                        bus_rdata_o <= '0;
    end
  end

  // R5
  stat_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && bus_wdata_i[0] && flag[0] && !(bus_rd_i && sel[0])) |=> flag[0]);
endmodule

// File: tb/dual_alarm_irq_bench.sv
module dual_alarm_irq_bench;
  logic       clk = 0, rst = 1, tick = 0, wr = 0, rd = 0;
  logic [7:0] t_s = 0, t_m = 0, t_h = 0, t_w = 0, addr = 0, wdata = 0;
  logic [7:0] rdata;
  logic       irq0_n, irq1_n;
  int         errors = 0, checks = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  dual_alarm_irq u_dual_alarm_irq (
    .clk(clk), .rst(rst), .tick_i(tick),
    .now_sec_i(t_s), .now_min_i(t_m), .now_hour_i(t_h), .now_wday_i(t_w),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq0_n_o(irq0_n), .irq1_n_o(irq1_n));

  // {alarm sec,min,hour,wday, time sec,min,hour,wday, expected match}
  localparam logic [64:0] VEC [7] = '{
    {32'h30_45_12_03, 32'h30_45_12_03, 1'b1},
    {32'h30_45_12_03, 32'h31_45_12_03, 1'b0},
    {32'h80_80_80_80, 32'h59_59_23_07, 1'b1},
    {32'h80_10_80_80, 32'h22_10_05_02, 1'b1},
    {32'h80_10_80_80, 32'h22_11_05_02, 1'b0},
    {32'h00_00_52_80, 32'h00_00_12_01, 1'b0},
    {32'h00_00_72_80, 32'h00_00_72_05, 1'b1}
  };

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0; d = rdata;
  endtask

  task automatic do_tick(logic [31:0] t);
    @(negedge clk); {t_s, t_m, t_h, t_w} = t; tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_alarm(int base, logic [31:0] f);
    wr_reg(8'(base),     f[31:24]);
    wr_reg(8'(base + 1), f[23:16]);
    wr_reg(8'(base + 2), f[15:8]);
    wr_reg(8'(base + 3), f[7:0]);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got %h expected %h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    idle(3); rst = 0; idle(1);

    // R10 reset state
    chk("R10 irq0", {7'b0, irq0_n}, 8'h01);
    chk("R10 irq1", {7'b0, irq1_n}, 8'h01);
    rd_reg(8'h10, d); chk("R10 status", d, 8'h00);
    rd_reg(8'h0F, d); chk("R10 control", d, 8'h00);
    rd_reg(8'h09, d); chk("R10 alarm field", d, 8'h00);

    // R2 R3 table walk on alarm 0
    foreach (VEC[i]) begin
      set_alarm(7, VEC[i][64:33]);
      wr_reg(8'h10, 8'h00);
      do_tick(VEC[i][32:1]);
      rd_reg(8'h10, d);
      chk($sformatf("R2/R3 vector %0d", i), d & 8'h01, {7'b0, VEC[i][0]});
    end

    // R1 register readback
    set_alarm(11, 32'h11_22_C3_84);
    rd_reg(8'h0B, d); chk("R1 alarm1 sec", d, 8'h11);
    rd_reg(8'h0D, d); chk("R1 alarm1 hour", d, 8'hC3);
    wr_reg(8'h0F, 8'hFF);
    rd_reg(8'h0F, d); chk("R1 control width", d, 8'h07);

    // R4 no tick, no flag; sticky through non-matching ticks
    wr_reg(8'h0F, 8'h00);
    set_alarm(7, 32'h05_80_80_80);
    set_alarm(11, 32'h80_80_80_80);
    wr_reg(8'h10, 8'h00);
    {t_s, t_m, t_h, t_w} = 32'h05_00_00_01; idle(4);
    rd_reg(8'h10, d); chk("R4 no tick", d, 8'h00);
    do_tick(32'h05_00_00_01);
    do_tick(32'h06_00_00_01);
    rd_reg(8'h10, d); chk("R4 sticky", d, 8'h03);

    // R8 enable alarm 0 -> irq0 low one clock after
    wr_reg(8'h0F, 8'h01); idle(1);
    chk("R8 irq0 low", {7'b0, irq0_n}, 8'h00);
    chk("R8 irq1 high", {7'b0, irq1_n}, 8'h01);

    // R9 disable -> pin released, flag kept
    wr_reg(8'h0F, 8'h00); idle(1);
    chk("R9 irq0 released", {7'b0, irq0_n}, 8'h01);
    rd_reg(8'h10, d); chk("R9 flag kept", d, 8'h03);

    // R6 read of alarm 0 clears only flag 0
    rd_reg(8'h08, d);
    rd_reg(8'h10, d); chk("R6 only alarm0 cleared", d, 8'h02);

    // R8 routing: alarm1 on irq0 when route bit clear, irq1 when set
    wr_reg(8'h0F, 8'h02); idle(1);
    chk("R8 shared irq0", {7'b0, irq0_n}, 8'h00);
    chk("R8 shared irq1", {7'b0, irq1_n}, 8'h01);
    wr_reg(8'h0F, 8'h06); idle(1);
    chk("R8 routed irq0", {7'b0, irq0_n}, 8'h01);
    chk("R8 routed irq1", {7'b0, irq1_n}, 8'h00);

    // R5 status write: zeros clear, ones keep
    do_tick(32'h05_00_00_01);
    wr_reg(8'h10, 8'h01);
    rd_reg(8'h10, d); chk("R5 partial clear", d, 8'h01);

    // R7 match and read-clear in the same cycle
    @(negedge clk); {t_s, t_m, t_h, t_w} = 32'h05_00_00_01; tick = 1; rd = 1; addr = 8'h07;
    @(negedge clk); tick = 0; rd = 0;
    chk("R7 read data", rdata, 8'h05);
    rd_reg(8'h10, d); chk("R7 read vs match", d & 8'h01, 8'h01);

    // R7 match and status-write-zero in the same cycle
    @(negedge clk); tick = 1; wr = 1; addr = 8'h10; wdata = 8'h00;
    @(negedge clk); tick = 0; wr = 0;
    rd_reg(8'h10, d); chk("R7 write vs match", d, 8'h03);

    // R6 read of alarm 1 clears only flag 1
    rd_reg(8'h0E, d);
    rd_reg(8'h10, d); chk("R6 only alarm1 cleared", d, 8'h01);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule